// File: doc/BRIEF.md
# BSC Block Check Accumulator (CRC-16)

This block follows a byte stream of binary synchronous link characters and keeps the 16-bit cyclic block check for the current block. The control characters in the stream decide what happens. A start-of-heading or start-of-text character opens a block. Synchronous idles are skipped. An intermediate-block character closes one check span and opens the next. An end-of-block or end-of-text character closes the block. In transparent text, only escaped control characters count as controls. The escape itself is dropped from the check, and bare control codes are treated as data.

Each character is applied to the generator x^16 + x^15 + x^2 + 1 one bit at a time, least significant bit first, starting from zero. After a block-ending character, the block emits a one-cycle "check now" strobe. It then takes the next two characters as the received check, keeps them out of the accumulation, and reports whether they equal the computed remainder. A transmitter uses `crcOut` when `checkNow` fires. A receiver uses `cmpValid` and `cmpMatch`.

Top module: `bsc_crc_acc`

## Requirements
- R1: The remainder starts at zero. Each accumulated character is applied least significant bit first with the generator polynomial 0x8005, with the register's bit 15 as the feedback tap. The characters 0xE3 then 0x2F must give `crcOut` = 0x1037.
- R2: While idle, characters other than SOH (0x01) and STX (0x02) have no effect. The first SOH or STX clears the register and is not accumulated. `crcOut` changes on the clock edge that accepts a character.
- R3: SYN (0x32) is never accumulated, in any mode.
- R4: In normal text, ITB (0x1F) is accumulated and the check is taken. After the check characters, the register is cleared and accumulation resumes with the next non-SYN character.
- R5: In normal text, ETB (0x26) or ETX (0x03) is accumulated and the check is taken. After that, everything is ignored until a new SOH or STX.
- R6: `checkNow` is high for exactly one cycle, in the cycle after the block-ending character is accepted. In that cycle `crcOut` already includes that character.
- R7: With `transparent` high, an unescaped DLE (0x10) is not accumulated and marks the next character as escaped. DLE DLE accumulates one DLE. Bare ETB, ETX and ITB are data. An escaped ETB, ETX or ITB ends the block as in R4 and R5.
- R8: With `transparent` high, a DLE STX that follows a heading (a block opened by SOH) or follows an intermediate block accumulates both DLE and STX, once. Any other DLE STX inside a block accumulates only the STX.
- R9: The two valid characters after a block end are the received check and are never accumulated. The first carries remainder bits 15..8 and the second bits 7..0, with remainder bit 15 (resp. 7) in character bit 0. After the second character, `cmpValid` pulses for one cycle, with `cmpMatch` high only if the received value equals the remainder.
- R10: In normal text, DLE is ordinary data, and an STX inside a block is accumulated.
- R11: After reset, `crcOut` is 0, `checkNow`, `cmpValid` and `cmpMatch` are low, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | `inByte` holds a character this cycle |
| inByte | input | 8 | Link character, bit 0 sent first |
| transparent | input | 1 | Transparent-text mode for this character |
| crcOut | output | 16 | Running remainder |
| checkNow | output | 1 | One-cycle strobe at a block end |
| cmpValid | output | 1 | Received-check comparison result is valid |
| cmpMatch | output | 1 | Received check equals remainder |

## Verification
The assertions assume that `inByte` and `transparent` are meaningful only while `inValid` is high. They also assume that the mode flag does not change between a DLE and the character it escapes. The stimulus holds `transparent` constant across every escape pair and drives characters on falling edges. It sends the check characters right after each block end, with no gap in `inValid`, so the strobe, the exclusion of the check characters and the comparison are all seen in adjacent cycles.

// File: rtl/bsc_crc_pkg.sv
package bsc_crc_pkg;
  localparam int CHAR_W = 8;

  localparam logic [CHAR_W-1:0] CH_SYN = 8'h32;
  localparam logic [CHAR_W-1:0] CH_DLE = 8'h10;
  localparam logic [CHAR_W-1:0] CH_SOH = 8'h01;
  localparam logic [CHAR_W-1:0] CH_STX = 8'h02;
  localparam logic [CHAR_W-1:0] CH_ETB = 8'h26;
  localparam logic [CHAR_W-1:0] CH_ETX = 8'h03;
  localparam logic [CHAR_W-1:0] CH_ITB = 8'h1F;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_CHECK = 2'd2
  } accState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;      // load zero into the remainder
    logic accByte;  // fold inByte into the remainder
    logic accDle;   // fold a DLE in before inByte
    logic capChk;   // shift in a received check character
    logic cmpDo;    // last check character: compare
  } dpStrobe_t;
endpackage

// File: rtl/bsc_crc_ctl.sv
module bsc_crc_ctl
  import bsc_crc_pkg::*;
#(
  parameter int NUM_CHK = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CHAR_W-1:0] inByte,
  input  logic              transparent,
  output dpStrobe_t         stb,
  output logic              checkNow
);
  localparam int CNT_W = (NUM_CHK > 1) ? $clog2(NUM_CHK) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_CHK - 1);

  accState_t       state, stateN;
  logic [CNT_W-1:0] chkCnt, chkCntN;
  logic            dlePend, dlePendN;   // R7 escape seen
  logic            hdrOk, hdrOkN;       // R8 DLE STX may fold its DLE
  logic            endItb, endItbN;     // R4 resume after check
  logic            endHit, endIsItb;

  logic isSyn, isDle, isStx, isSoh, isItb, isEnd;
  assign isSyn = (inByte == CH_SYN);
  assign isDle = (inByte == CH_DLE);
  assign isStx = (inByte == CH_STX);
  assign isSoh = (inByte == CH_SOH);
  assign isItb = (inByte == CH_ITB);
  assign isEnd = (inByte == CH_ETB) || (inByte == CH_ETX);

  always_comb begin
    stb      = '0;
    stateN   = state;
    chkCntN  = chkCnt;
    dlePendN = dlePend;
    hdrOkN   = hdrOk;
    endItbN  = endItb;
    endHit   = 1'b0;
    endIsItb = 1'b0;
    if (inValid) begin
      unique case (state)
        ST_IDLE: begin
          // R2 only a start character opens a block
          if (isSoh || isStx) begin
            stb.clr  = 1'b1;
            stateN   = ST_ACCUM;
            hdrOkN   = isSoh;
            dlePendN = 1'b0;
          end
        end
        ST_ACCUM: begin
          dlePendN = 1'b0;
          if (isSyn) begin
            // R3 skipped; a pending escape is consumed (DLE SYN)
          end else if (transparent && !dlePend) begin
            if (isDle) dlePendN = 1'b1;     // R7 escape not folded
            else       stb.accByte = 1'b1;  // R7 bare controls are data
          end else if (transparent) begin
            stb.accByte = 1'b1;
            if (isStx) begin
              stb.accDle = hdrOk;           // R8
              hdrOkN     = 1'b0;
            end else if (isItb) begin
              endHit = 1'b1; endIsItb = 1'b1;
            end else if (isEnd) begin
              endHit = 1'b1;
            end
          end else begin
            stb.accByte = 1'b1;             // R10 DLE and STX are data here
            if (isStx) hdrOkN = 1'b0;
            if (isItb) begin
              endHit = 1'b1; endIsItb = 1'b1;  // R4
            end else if (isEnd) begin
              endHit = 1'b1;                   // R5
            end
          end
          if (endHit) begin
            stateN   = ST_CHECK;
            chkCntN  = '0;
            endItbN  = endIsItb;
            dlePendN = 1'b0;
          end
        end
        ST_CHECK: begin
          // R9 check characters are taken raw
          if (chkCnt == CNT_LAST) begin
            stb.cmpDo = 1'b1;
            if (endItb) begin
              stb.clr = 1'b1;               // R4 clear and resume
              stateN  = ST_ACCUM;
              hdrOkN  = 1'b1;
            end else begin
              stateN  = ST_IDLE;            // R5 stop
            end
          end else begin
            stb.capChk = 1'b1;
            chkCntN    = chkCnt + 1'b1;
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      chkCnt   <= '0;
      dlePend  <= 1'b0;
      hdrOk    <= 1'b0;
      endItb   <= 1'b0;
      checkNow <= 1'b0;
    end else begin
      state    <= stateN;
      chkCnt   <= chkCntN;
      dlePend  <= dlePendN;
      hdrOk    <= hdrOkN;
      endItb   <= endItbN;
      checkNow <= endHit;                   // R6
    end
  end

  AST_CLR_ACC_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.clr && stb.accByte)); // R2
  AST_CHK_NO_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK) |-> !stb.accByte); // R9
endmodule

// File: rtl/bsc_crc_dp.sv
module bsc_crc_dp
  import bsc_crc_pkg::*;
#(
  parameter int              CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] inByte,
  input  dpStrobe_t         stb,
  output logic [CRC_W-1:0]  crcOut,
  output logic              cmpValid,
  output logic              cmpMatch
);
  localparam int KEEP_W = CRC_W - CHAR_W;

  // R1 one character, bit 0 first, MSB-tap register
  function automatic logic [CRC_W-1:0] foldChar(input logic [CRC_W-1:0] r,
                                                input logic [CHAR_W-1:0] c);
    logic [CRC_W-1:0] v;
    logic fb;
    v = r;
    for (int i = 0; i < CHAR_W; i++) begin
      fb = c[i] ^ v[CRC_W-1];
      v  = {v[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return v;
  endfunction

  // R9 bit 0 of a check character is the higher remainder bit
  function automatic logic [CHAR_W-1:0] flipChar(input logic [CHAR_W-1:0] c);
    logic [CHAR_W-1:0] f;
    for (int i = 0; i < CHAR_W; i++) f[i] = c[CHAR_W-1-i];
    return f;
  endfunction

  logic [CRC_W-1:0] crcReg, crcN, preDle;
  logic [CRC_W-1:0] chkShift, chkFull;

  assign preDle  = stb.accDle ? foldChar(crcReg, CH_DLE) : crcReg;  // R8
  assign chkFull = {chkShift[KEEP_W-1:0], flipChar(inByte)};

  always_comb begin
    crcN = crcReg;
    if (stb.clr)          crcN = '0;
    else if (stb.accByte) crcN = foldChar(preDle, inByte);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg   <= '0;
      chkShift <= '0;
      cmpValid <= 1'b0;
      cmpMatch <= 1'b0;
    end else begin
      crcReg   <= crcN;
      if (stb.capChk) chkShift <= chkFull;
      cmpValid <= stb.cmpDo;
      cmpMatch <= stb.cmpDo && (chkFull == crcReg);
    end
  end

  assign crcOut = crcReg;

  AST_DLE_WITH_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    stb.accDle |-> stb.accByte); // R8
endmodule

// File: rtl/bsc_crc_acc.sv
module bsc_crc_acc
  import bsc_crc_pkg::*;
#(
  parameter int              CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  input  logic              transparent,
  output logic [CRC_W-1:0]  crcOut,
  output logic              checkNow,
  output logic              cmpValid,
  output logic              cmpMatch
);
  localparam int NUM_CHK = CRC_W / CHAR_W;

  dpStrobe_t stb;

  bsc_crc_ctl #(.NUM_CHK(NUM_CHK)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .transparent(transparent), .stb(stb), .checkNow(checkNow)
  );

  bsc_crc_dp #(.CRC_W(CRC_W), .POLY(POLY)) u_dp (
    .clk(clk), .rstN(rstN), .inByte(inByte), .stb(stb),
    .crcOut(crcOut), .cmpValid(cmpValid), .cmpMatch(cmpMatch)
  );

  AST_SYN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inByte == CH_SYN && !stb.capChk && !stb.cmpDo) |=> $stable(crcOut)); // R3
  AST_CHECK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    checkNow |=> !checkNow); // R6
  AST_NO_EARLY_CMP: assert property (@(posedge clk) disable iff (!rstN)
    checkNow |-> !cmpValid); // R9
  AST_MATCH_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    cmpMatch |-> cmpValid); // R9
  AST_CHK_EXCLUDED: assert property (@(posedge clk) disable iff (!rstN)
    stb.capChk |=> $stable(crcOut)); // R9
endmodule

// File: tb/bsc_crc_acc_bench.sv
module bsc_crc_acc_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic transparent = 1'b0;
  logic [15:0] crcOut;
  logic checkNow, cmpValid, cmpMatch;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bsc_crc_acc u_bsc_crc_acc (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .transparent(transparent), .crcOut(crcOut), .checkNow(checkNow),
    .cmpValid(cmpValid), .cmpMatch(cmpMatch)
  );

  localparam logic [3:0] A_IGN = 4'd0, A_ACC = 4'd1, A_ACC2 = 4'd2, A_CLR = 4'd3,
                         A_ENDI = 4'd4, A_ENDE = 4'd5, A_CBG = 4'd6, A_CBB = 4'd7,
                         A_CB2 = 4'd8;
  localparam int NV = 52;
  // {transparent, character, expected action}
  localparam logic [12:0] VECS [0:NV-1] = '{
    {1'b0, 8'h41, A_IGN},  {1'b0, 8'h32, A_IGN},  {1'b0, 8'h02, A_CLR},   // R2
    {1'b0, 8'hE3, A_ACC},  {1'b0, 8'h2F, A_ACC},                          // R1
    {1'b0, 8'h32, A_IGN},  {1'b0, 8'h03, A_ENDE},                         // R3 R5
    {1'b0, 8'h00, A_CBG},  {1'b0, 8'h00, A_CB2},
    {1'b0, 8'h55, A_IGN},  {1'b0, 8'h01, A_CLR},  {1'b0, 8'hC1, A_ACC},   // R5 R2
    {1'b0, 8'h02, A_ACC},  {1'b0, 8'h10, A_ACC},  {1'b0, 8'h32, A_IGN},   // R10
    {1'b0, 8'h1F, A_ENDI}, {1'b0, 8'h00, A_CBB},  {1'b0, 8'h00, A_CB2},   // R4 R9
    {1'b0, 8'h32, A_IGN},  {1'b0, 8'h7A, A_ACC},  {1'b0, 8'h26, A_ENDE},
    {1'b0, 8'h00, A_CBG},  {1'b0, 8'h00, A_CB2},
    {1'b1, 8'h10, A_IGN},  {1'b1, 8'h02, A_CLR},  {1'b1, 8'h03, A_ACC},   // R7
    {1'b1, 8'h10, A_IGN},  {1'b1, 8'h10, A_ACC},  {1'b1, 8'h26, A_ACC},
    {1'b1, 8'h10, A_IGN},  {1'b1, 8'h02, A_ACC},                          // R8 no heading
    {1'b1, 8'h10, A_IGN},  {1'b1, 8'h32, A_IGN},
    {1'b1, 8'h10, A_IGN},  {1'b1, 8'h1F, A_ENDI},
    {1'b1, 8'h00, A_CBG},  {1'b1, 8'h00, A_CB2},
    {1'b1, 8'h10, A_IGN},  {1'b1, 8'h02, A_ACC2}, {1'b1, 8'h99, A_ACC},   // R8 after ITB
    {1'b1, 8'h10, A_IGN},  {1'b1, 8'h03, A_ENDE},
    {1'b1, 8'h00, A_CBG},  {1'b1, 8'h00, A_CB2},
    {1'b1, 8'h01, A_CLR},  {1'b1, 8'h44, A_ACC},                          // R8 heading
    {1'b1, 8'h10, A_IGN},  {1'b1, 8'h02, A_ACC2},
    {1'b1, 8'h10, A_IGN},  {1'b1, 8'h26, A_ENDE},
    {1'b1, 8'h00, A_CBG},  {1'b1, 8'h00, A_CB2}
  };

  // bit-serial reference built from R1
  function automatic logic [15:0] refFold(input logic [15:0] r, input logic [7:0] c);
    logic [15:0] v = r;
    for (int k = 0; k < 8; k++) begin
      if (c[k] != v[15]) v = (v << 1) ^ 16'h8005;
      else               v = v << 1;
    end
    return v;
  endfunction

  function automatic logic [7:0] refFlip(input logic [7:0] c);
    logic [7:0] f;
    for (int k = 0; k < 8; k++) f[k] = c[7-k];
    return f;
  endfunction

  function automatic string reqOf(input logic [3:0] a, input logic xp);
    case (a)
      A_IGN:  return "R2 R3 R5 R7";
      A_ACC:  return xp ? "R7" : "R1 R10";
      A_ACC2: return "R8";
      A_CLR:  return "R2";
      A_ENDI: return "R4 R6";
      A_ENDE: return "R5 R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [15:0] expCrc;
    logic [15:0] sentCrc;
    bit good, pendClr;
    expCrc = 16'h0; sentCrc = 16'h0; good = 1'b0; pendClr = 1'b0;

    repeat (3) @(negedge clk);
    // R11 reset state
    check(crcOut == 16'h0 && !checkNow && !cmpValid && !cmpMatch, "R11", "reset outputs",
          {13'h0, checkNow, cmpValid, cmpMatch, crcOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] a;
      logic [7:0] b;
      bit eChk, eCmp, eMatch;
      a = VECS[i][3:0];
      b = VECS[i][11:4];
      eChk = 1'b0; eCmp = 1'b0; eMatch = 1'b0;
      case (a)
        A_ACC:  expCrc = refFold(expCrc, b);
        A_ACC2: expCrc = refFold(refFold(expCrc, 8'h10), b);
        A_CLR:  expCrc = 16'h0;
        A_ENDI: begin expCrc = refFold(expCrc, b); eChk = 1'b1; pendClr = 1'b1; end
        A_ENDE: begin expCrc = refFold(expCrc, b); eChk = 1'b1; pendClr = 1'b0; end
        A_CBG:  begin sentCrc = expCrc; b = refFlip(expCrc[15:8]); good = 1'b1; end
        A_CBB:  begin sentCrc = expCrc; b = refFlip(expCrc[15:8]) ^ 8'h01; good = 1'b0; end
        A_CB2:  begin
          b = refFlip(sentCrc[7:0]); eCmp = 1'b1; eMatch = good;
          if (pendClr) expCrc = 16'h0;
        end
        default: ;
      endcase
      transparent = VECS[i][12];
      inByte = b;
      inValid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(crcOut == expCrc && checkNow == eChk && cmpValid == eCmp && cmpMatch == eMatch,
            reqOf(a, VECS[i][12]), $sformatf("vector %0d {crc,chk,cmpV,cmpM}", i),
            {13'h0, checkNow, cmpValid, cmpMatch, crcOut},
            {13'h0, eChk, eCmp, eMatch, expCrc});
      if (i == 4)
        check(crcOut == 16'h1037, "R1", "known vector remainder", {16'h0, crcOut}, 32'h1037);
    end

    // R6: strobe gone one cycle later with no traffic
    inValid = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!checkNow && !cmpValid, "R6", "strobes low when idle",
          {30'h0, checkNow, cmpValid}, 32'h0);

    // R11: reset in mid-block returns to idle
    transparent = 1'b0;
    inValid = 1'b1; inByte = 8'h02;
    @(posedge clk); @(negedge clk);
    inByte = 8'h5A;
    @(posedge clk); @(negedge clk);
    check(crcOut == refFold(16'h0, 8'h5A), "R1", "block before reset",
          {16'h0, crcOut}, {16'h0, refFold(16'h0, 8'h5A)});
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1;
    check(crcOut == 16'h0, "R11", "remainder after reset", {16'h0, crcOut}, 32'h0);
    inByte = 8'h5A;
    @(posedge clk); @(negedge clk);
    check(crcOut == 16'h0, "R11", "idle after reset ignores data", {16'h0, crcOut}, 32'h0);
    inValid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule